// File: doc/BRIEF.md
# Critical Interrupt Entry and Return Unit

This unit sits beside a processor core's sequencer and handles one high-priority, level-sensitive interrupt line. At each instruction boundary it looks at the live level of the line and at the critical-enable bit of the current machine state. When both are set and no critical handler is already running, it takes the interrupt in that cycle. Taking the interrupt stores the resume address and the low half of the machine state in a private pair of save registers. It then produces an updated machine state and a redirect to the handler vector.

A separate return command, given while the handler is running, redirects the core back to the saved address. It also restores the low half of the machine state from the second save register. Instruction decode and saving of general registers are done elsewhere.

The control is a two-state machine. `ST_RUN` is normal execution. `ST_CRIT` means the critical handler is active. Transition `TAKE` (`ST_RUN` to `ST_CRIT`) fires on an accepted request. Transition `RETURN` (`ST_CRIT` to `ST_RUN`) fires on a return command. A return command in `ST_RUN` is dropped and leaves the state unchanged. All outputs are registered, so they appear one clock after the boundary or command that caused them.

Top module: `crit_irq_unit`

## Requirements
- R1: At a cycle where `bnd_i`=1, `irq_lvl_i`=1, `msr_i[7]` (critical enable)=1 and the state is `ST_RUN`, the interrupt is taken. In the next cycle `taken_o`, `redir_vld_o` and `msr_wr_o` are 1. A taken interrupt moves the state to `ST_CRIT`.
- R2: While `msr_i[7]`=0 at the boundary, the request is ignored: no taken pulse, no redirect and no machine-state write follow.
- R3: Acceptance uses only the level present in the boundary cycle. A request that is high between boundaries and low at the boundary is never taken.
- R4: On entry, the first save register captures `nia_i`. A later return redirects to exactly that address.
- R5: On entry, the second save register captures `msr_i[15:0]`, with its upper 16 bits cleared. A later return places those 16 bits in `msr_new_o[15:0]`.
- R6: On entry, `msr_new_o` equals `msr_i` with bits 18,17,15,14,13,11,10,9,8,7,5,4,1 cleared. Bit 0 (little-endian mode) is loaded from `ile_i`. Every other bit is kept, including bit 12 (machine-check enable), bit 6 (vector select) and bit 16.
- R7: On entry, `redir_addr_o` = (`msr_i[6]` ? 0xFFF00000 : 0) + 0x00000A00.
- R8: `taken_o` and the entry redirect are single-cycle pulses.
- R9: In `ST_CRIT`, requests are not taken even when `msr_i[7]`=1 at a boundary.
- R10: `rfci_i`=1 in `ST_CRIT` gives, in the next cycle: `redir_vld_o`=1 and `msr_wr_o`=1 with `taken_o`=0, `redir_addr_o` = the saved address, and `msr_new_o` = {`msr_i[31:16]`, saved low half}. It also returns the state to `ST_RUN`, so a request can be taken again.
- R11: `rfci_i`=1 in `ST_RUN` is ignored: no redirect and no machine-state write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| irq_lvl_i | input | 1 | Level-sensitive critical interrupt request |
| nia_i | input | AW | Address of the next instruction to execute |
| msr_i | input | 32 | Current machine state |
| bnd_i | input | 1 | Instruction-boundary strobe |
| rfci_i | input | 1 | Return-from-critical-interrupt command |
| ile_i | input | 1 | Little-endian mode to apply in the handler |
| taken_o | output | 1 | One-cycle pulse: interrupt taken |
| redir_vld_o | output | 1 | One-cycle pulse: fetch redirect valid |
| redir_addr_o | output | AW | Redirect fetch address |
| msr_wr_o | output | 1 | One-cycle pulse: write `msr_new_o` into the machine state |
| msr_new_o | output | 32 | New machine state value |

## Verification
If the state register holds a wrong value, the fault shows at the ports at the next boundary or return command. A request that should be accepted produces no `taken_o` pulse, or a return produces no redirect, or a blocked request gets through while the handler runs. A corrupted save register stays hidden until the matching return. There it appears as a wrong `redir_addr_o` or a wrong low half of `msr_new_o`, one cycle after `rfci_i`. A wrong entry transform or vector shows in the cycle right after the boundary that took the interrupt.

// File: rtl/cie_pkg.sv
package cie_pkg;

    localparam int MSR_W  = 32;
    localparam int HALF_W = 16;

    // machine state field positions (bit 0 = least significant)
    localparam int F_LE        = 0;
    localparam int F_RECOV     = 1;
    localparam int F_DXLAT     = 4;
    localparam int F_IXLAT     = 5;
    localparam int F_VEC_HI    = 6;
    localparam int F_CRIT_EN   = 7;
    localparam int F_FPX1      = 8;
    localparam int F_BR_TRACE  = 9;
    localparam int F_STEP      = 10;
    localparam int F_FPX0      = 11;
    localparam int F_MCHK_EN   = 12;
    localparam int F_FP_AVAIL  = 13;
    localparam int F_USER      = 14;
    localparam int F_EXT_EN    = 15;
    localparam int F_TMP_GPR   = 17;
    localparam int F_PWR_SAVE  = 18;

    typedef enum logic [0:0] {
        ST_RUN  = 1'b0,
        ST_CRIT = 1'b1
    } cie_state_e;

    function automatic logic [MSR_W-1:0] entry_clear_mask();
        logic [MSR_W-1:0] m;
        m = '0;
        m[F_RECOV]    = 1'b1;
        m[F_DXLAT]    = 1'b1;
        m[F_IXLAT]    = 1'b1;
        m[F_CRIT_EN]  = 1'b1;
        m[F_FPX1]     = 1'b1;
        m[F_BR_TRACE] = 1'b1;
        m[F_STEP]     = 1'b1;
        m[F_FPX0]     = 1'b1;
        m[F_FP_AVAIL] = 1'b1;
        m[F_USER]     = 1'b1;
        m[F_EXT_EN]   = 1'b1;
        m[F_TMP_GPR]  = 1'b1;
        m[F_PWR_SAVE] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/cie_gate.sv
module cie_gate (
    input  logic irq_lvl,
    input  logic bnd,
    input  logic crit_en,
    input  logic in_handler,
    input  logic ret_cmd,
    output logic take,
    output logic ret_go
);
    always_comb begin
        ret_go = ret_cmd & in_handler;
        take   = irq_lvl & bnd & crit_en & ~in_handler;
    end
endmodule

// File: rtl/cie_xform.sv
module cie_xform #(
    parameter int               AW      = 32,
    parameter logic [AW-1:0]    HI_BASE = 32'hFFF0_0000,
    parameter logic [AW-1:0]    VEC_OFF = 32'h0000_0A00
) (
    input  logic [cie_pkg::MSR_W-1:0]  msr,
    input  logic                       ile,
    output logic [cie_pkg::MSR_W-1:0]  entry_msr,
    output logic [cie_pkg::HALF_W-1:0] save_lo,
    output logic [AW-1:0]              vec_addr
);
    import cie_pkg::*;

    localparam logic [MSR_W-1:0] CLR_MASK = entry_clear_mask();

    always_comb begin
        entry_msr       = msr & ~CLR_MASK;
        entry_msr[F_LE] = ile;
        save_lo         = msr[HALF_W-1:0];
        vec_addr        = (msr[F_VEC_HI] ? HI_BASE : '0) + VEC_OFF;
    end
endmodule

// File: rtl/cie_save.sv
module cie_save #(
    parameter int AW = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cap,
    input  logic [AW-1:0]              addr_in,
    input  logic [cie_pkg::HALF_W-1:0] lo_in,
    output logic [AW-1:0]              addr_q,
    output logic [cie_pkg::HALF_W-1:0] lo_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            lo_q   <= '0;
        end else if (cap) begin
            addr_q <= addr_in;
            lo_q   <= lo_in;
        end
    end

    AST_SAVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cap |=> $stable(addr_q) && $stable(lo_q)); // R4
endmodule

// File: rtl/crit_irq_unit.sv
module crit_irq_unit #(
    parameter int            AW      = 32,
    parameter logic [AW-1:0] HI_BASE = 32'hFFF0_0000,
    parameter logic [AW-1:0] VEC_OFF = 32'h0000_0A00
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      irq_lvl_i,
    input  logic [AW-1:0]             nia_i,
    input  logic [cie_pkg::MSR_W-1:0] msr_i,
    input  logic                      bnd_i,
    input  logic                      rfci_i,
    input  logic                      ile_i,
    output logic                      taken_o,
    output logic                      redir_vld_o,
    output logic [AW-1:0]             redir_addr_o,
    output logic                      msr_wr_o,
    output logic [cie_pkg::MSR_W-1:0] msr_new_o
);
    import cie_pkg::*;

    cie_state_e          state, state_nx;
    logic                take, ret_go;
    logic [MSR_W-1:0]    entry_msr;
    logic [HALF_W-1:0]   save_lo_d, save_lo_q;
    logic [AW-1:0]       vec_addr, save_addr_q;

    cie_gate u_gate (
        .irq_lvl    (irq_lvl_i),
        .bnd        (bnd_i),
        .crit_en    (msr_i[F_CRIT_EN]),
        .in_handler (state == ST_CRIT),
        .ret_cmd    (rfci_i),
        .take       (take),
        .ret_go     (ret_go)
    );

    cie_xform #(.AW(AW), .HI_BASE(HI_BASE), .VEC_OFF(VEC_OFF)) u_xform (
        .msr       (msr_i),
        .ile       (ile_i),
        .entry_msr (entry_msr),
        .save_lo   (save_lo_d),
        .vec_addr  (vec_addr)
    );

    cie_save #(.AW(AW)) u_save (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap     (take),
        .addr_in (nia_i),
        .lo_in   (save_lo_d),
        .addr_q  (save_addr_q),
        .lo_q    (save_lo_q)
    );

    // next-state logic: TAKE and RETURN transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_RUN:  if (take)   state_nx = ST_CRIT;
            ST_CRIT: if (ret_go) state_nx = ST_RUN;
            default: state_nx = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= state_nx;
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            taken_o      <= 1'b0;
            redir_vld_o  <= 1'b0;
            msr_wr_o     <= 1'b0;
            redir_addr_o <= '0;
            msr_new_o    <= '0;
        end else begin
            taken_o     <= take;
            redir_vld_o <= take | ret_go;
            msr_wr_o    <= take | ret_go;
            if (take) begin
                redir_addr_o <= vec_addr;
                msr_new_o    <= entry_msr;
            end else if (ret_go) begin
                redir_addr_o <= save_addr_q;
                msr_new_o    <= {msr_i[MSR_W-1:HALF_W], save_lo_q};
            end
        end
    end

    AST_TAKE_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (bnd_i && irq_lvl_i && msr_i[F_CRIT_EN] && state == ST_RUN) |=> taken_o && state == ST_CRIT); // R1
    AST_CE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (bnd_i && !msr_i[F_CRIT_EN]) |=> !taken_o); // R2
    AST_LEVEL_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_lvl_i || !bnd_i) |=> !taken_o); // R3
    AST_ENTRY_CE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        taken_o |-> (msr_wr_o && !msr_new_o[F_CRIT_EN] && !msr_new_o[F_EXT_EN])); // R6
    AST_TAKEN_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        taken_o |=> !taken_o); // R8
    AST_CRIT_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CRIT) |=> !taken_o); // R9
    AST_RET_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        (rfci_i && state == ST_CRIT) |=> (state == ST_RUN && redir_vld_o && !taken_o)); // R10
    AST_RET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (rfci_i && state == ST_RUN && !bnd_i) |=> !redir_vld_o && !msr_wr_o); // R11
endmodule

// File: tb/crit_irq_unit_test.sv
module crit_irq_unit_test;
    localparam int TCLK = 10;
    localparam logic [31:0] CLR = 32'h0006_EFB2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        irq_lvl_i = 1'b0, bnd_i = 1'b0, rfci_i = 1'b0, ile_i = 1'b0;
    logic [31:0] nia_i = '0, msr_i = '0;
    logic        taken_o, redir_vld_o, msr_wr_o;
    logic [31:0] redir_addr_o, msr_new_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(TCLK/2) clk = ~clk;

    crit_irq_unit uut (
        .clk(clk), .rst_n(rst_n), .irq_lvl_i(irq_lvl_i), .nia_i(nia_i),
        .msr_i(msr_i), .bnd_i(bnd_i), .rfci_i(rfci_i), .ile_i(ile_i),
        .taken_o(taken_o), .redir_vld_o(redir_vld_o), .redir_addr_o(redir_addr_o),
        .msr_wr_o(msr_wr_o), .msr_new_o(msr_new_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_entry(input logic [31:0] m, input logic ile);
        logic [31:0] r;
        r = m & ~CLR;
        r[0] = ile;
        return r;
    endfunction

    function automatic logic [31:0] exp_vec(input logic [31:0] m);
        return (m[6] ? 32'hFFF0_0000 : 32'h0) + 32'h0000_0A00;
    endfunction

    task automatic idle_inputs();
        irq_lvl_i = 1'b0; bnd_i = 1'b0; rfci_i = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 reset taken", {31'b0, taken_o}, 32'd0);
        chk("R1 reset redir", {31'b0, redir_vld_o}, 32'd0);
        chk("R1 reset msr_wr", {31'b0, msr_wr_o}, 32'd0);
    endtask

    task automatic t_ce_clear();
        msr_i = 32'hFFFF_FF7F; irq_lvl_i = 1'b1; bnd_i = 1'b1; nia_i = 32'h100;
        @(negedge clk);
        chk("R2 taken", {31'b0, taken_o}, 32'd0);
        chk("R2 redir", {31'b0, redir_vld_o}, 32'd0);
        chk("R2 msr_wr", {31'b0, msr_wr_o}, 32'd0);
        idle_inputs();
    endtask

    task automatic t_level_drop();
        msr_i = 32'h0000_0080; irq_lvl_i = 1'b1; bnd_i = 1'b0;
        repeat (3) @(negedge clk);
        chk("R3 between boundaries", {31'b0, taken_o}, 32'd0);
        irq_lvl_i = 1'b0; bnd_i = 1'b1;
        @(negedge clk);
        chk("R3 dropped before boundary", {31'b0, taken_o}, 32'd0);
        idle_inputs();
        @(negedge clk);
        chk("R3 no late take", {31'b0, taken_o}, 32'd0);
    endtask

    task automatic t_entry(input logic [31:0] nia, input logic [31:0] m, input logic ile);
        nia_i = nia; msr_i = m; ile_i = ile; irq_lvl_i = 1'b1; bnd_i = 1'b1;
        @(negedge clk);
        chk("R1 taken", {31'b0, taken_o}, 32'd1);
        chk("R1 redir", {31'b0, redir_vld_o}, 32'd1);
        chk("R1 msr_wr", {31'b0, msr_wr_o}, 32'd1);
        chk("R6 entry msr", msr_new_o, exp_entry(m, ile));
        chk("R7 vector", redir_addr_o, exp_vec(m));
        bnd_i = 1'b0; nia_i = 32'hDEAD_0000; msr_i = 32'h0;
        @(negedge clk);
        chk("R8 taken pulse", {31'b0, taken_o}, 32'd0);
        chk("R8 redir pulse", {31'b0, redir_vld_o}, 32'd0);
    endtask

    task automatic t_blocked();
        msr_i = 32'h0000_00C0; irq_lvl_i = 1'b1; bnd_i = 1'b1;
        repeat (2) @(negedge clk);
        chk("R9 blocked in handler", {31'b0, taken_o}, 32'd0);
        chk("R9 no redirect", {31'b0, redir_vld_o}, 32'd0);
        idle_inputs();
    endtask

    task automatic t_return(input logic [31:0] hi_msr, input logic [31:0] nia, input logic [31:0] m);
        msr_i = hi_msr; rfci_i = 1'b1;
        @(negedge clk);
        chk("R10 redir", {31'b0, redir_vld_o}, 32'd1);
        chk("R10 msr_wr", {31'b0, msr_wr_o}, 32'd1);
        chk("R10 no taken", {31'b0, taken_o}, 32'd0);
        chk("R4 return address", redir_addr_o, nia);
        chk("R5 R10 restored msr", msr_new_o, {hi_msr[31:16], m[15:0]});
        rfci_i = 1'b0;
        @(negedge clk);
        chk("R10 redir pulse", {31'b0, redir_vld_o}, 32'd0);
    endtask

    task automatic t_ret_idle();
        rfci_i = 1'b1; msr_i = 32'h1111_2222;
        @(negedge clk);
        chk("R11 redir", {31'b0, redir_vld_o}, 32'd0);
        chk("R11 msr_wr", {31'b0, msr_wr_o}, 32'd0);
        rfci_i = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_ce_clear();
        t_level_drop();
        t_entry(32'h1234_5678, 32'hFFFF_FFFF, 1'b0);
        t_blocked();
        t_return(32'h5A5A_0000, 32'h1234_5678, 32'hFFFF_FFFF);
        t_ret_idle();
        t_entry(32'h0000_4000, 32'h0000_1081, 1'b1);
        t_return(32'hFFFF_0000, 32'h0000_4000, 32'h0000_1081);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule